// File: doc/BRIEF.md
# Halfword Transfer Unit

This block performs the halfword transfer operations of a 36-bit datapath whose words split into two 18-bit halves. Each operation takes one half of a source operand and places it in one half of the result. The half of the result that is not written is filled under a separate policy: it is copied from the accumulator, cleared, set to all ones, or filled with the sign bit of the half that was moved. A separate swap operation exchanges the two halves of the source.

The caller presents the operation fields, the source word and the accumulator word together with a one-cycle strobe. The result is registered and appears after the next rising clock edge. Between strobes the result holds its value. The block only forms the result word. Where the result is written afterwards, to memory or to the accumulator, is decided outside this block.

Top module: `halfword_xfer_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `res_word` becomes all zeros, whatever the other inputs are.
- R2: A strobe (`op_valid` high at a rising edge) loads the result of that cycle's inputs into `res_word`, visible after that edge. With `op_valid` low, `res_word` keeps its value no matter how the other inputs change.
- R3: The left half is bits 35:18 (the most significant end) and the right half is bits 17:0. The routing field `op_route` works as follows: 0 moves source left to result left, 1 moves source right to result right, 2 moves source right to result left, and 3 moves source left to result right.
- R4: When `op_fill` is 0 (keep), the other half of the result is the same half of `acc_word`.
- R5: When `op_fill` is 1 (zero), the other half is all zeros, and `acc_word` has no effect on the result.
- R6: When `op_fill` is 2 (ones), the other half is all ones, and `acc_word` has no effect on the result.
- R7: When `op_fill` is 3 (extend), every bit of the other half equals the sign of the moved half. That sign is `src_word[35]` when the source half is the left half (routings 0 and 3) and `src_word[17]` when it is the right half (routings 1 and 2).
- R8: When `op_swap` is 1, the result is source right in bits 35:18 and source left in bits 17:0. In that case `op_route`, `op_fill` and `acc_word` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Strobe that loads a new result |
| op_route | input | 2 | Selects which source half goes to which result half |
| op_fill | input | 2 | Fill policy for the other half: keep, zero, ones, extend |
| op_swap | input | 1 | Whole-word half exchange; overrides route and fill |
| src_word | input | 36 | Source operand |
| acc_word | input | 36 | Accumulator value used by keep fill |
| res_word | output | 36 | Registered result |

## Verification
The hardest case to reach is the extend fill. There the sign must come from the half that is actually moved, and the other source half must carry the opposite sign. Only then does taking the sign from the wrong bit change the result. The stimulus drives, for every routing, sources whose left and right halves have opposite signs, in both polarities. It also varies the accumulator and the unused fields between the swap, zero and ones operations. A result that leaks either of them then shows up at `res_word`.

// File: rtl/htu_pkg.sv
package htu_pkg;

    typedef enum logic [1:0] {
        RT_LL = 2'd0,
        RT_RR = 2'd1,
        RT_RL = 2'd2,
        RT_LR = 2'd3
    } route_e;

    typedef enum logic [1:0] {
        FL_KEEP = 2'd0,
        FL_ZERO = 2'd1,
        FL_ONES = 2'd2,
        FL_EXT  = 2'd3
    } fill_e;

    typedef struct packed {
        logic   swap;
        route_e route;
        fill_e  fill;
    } htu_op_t;

    // Source half is the right half for routings RR and RL.
    function automatic logic route_src_right(route_e r);
        return (r == RT_RR) || (r == RT_RL);
    endfunction

    // Destination half is the right half for routings RR and LR.
    function automatic logic route_dst_right(route_e r);
        return (r == RT_RR) || (r == RT_LR);
    endfunction

endpackage

// File: rtl/htu_route.sv
module htu_route
    import htu_pkg::*;
#(
    parameter int HALF_W = 18
) (
    input  route_e              route,
    input  logic [HALF_W-1:0]   src_hi,
    input  logic [HALF_W-1:0]   src_lo,
    output logic [HALF_W-1:0]   moved,
    output logic                dst_right
);

    logic take_lo;

    always_comb begin
        take_lo   = route_src_right(route);
        dst_right = route_dst_right(route);
        moved     = take_lo ? src_lo : src_hi;
    end

endmodule

// File: rtl/htu_fill.sv
module htu_fill
    import htu_pkg::*;
#(
    parameter int HALF_W = 18
) (
    input  fill_e               fill,
    input  logic                dst_right,
    input  logic [HALF_W-1:0]   moved,
    input  logic [HALF_W-1:0]   acc_hi,
    input  logic [HALF_W-1:0]   acc_lo,
    output logic [HALF_W-1:0]   other
);

    localparam int SIGN_POS = HALF_W - 1;

    logic [HALF_W-1:0] acc_other;
    logic [HALF_W-1:0] sign_fill;

    always_comb begin
        // The unwritten half sits opposite the destination half.
        acc_other = dst_right ? acc_hi : acc_lo;
        sign_fill = {HALF_W{moved[SIGN_POS]}};
        case (fill)
            FL_KEEP: other = acc_other;
            FL_ZERO: other = '0;
            FL_ONES: other = '1;
            FL_EXT:  other = sign_fill;
            default: other = '0;
        endcase
    end

endmodule

// File: rtl/htu_pack.sv
module htu_pack #(
    parameter int HALF_W = 18,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic                swap,
    input  logic                dst_right,
    input  logic [HALF_W-1:0]   moved,
    input  logic [HALF_W-1:0]   other,
    input  logic [HALF_W-1:0]   src_hi,
    input  logic [HALF_W-1:0]   src_lo,
    output logic [WORD_W-1:0]   word
);

    always_comb begin
        if (swap) begin
            word = {src_lo, src_hi};
        end else if (dst_right) begin
            word = {other, moved};
        end else begin
            word = {moved, other};
        end
    end

endmodule

// File: rtl/halfword_xfer_unit.sv
module halfword_xfer_unit
    import htu_pkg::*;
#(
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_route,
    input  logic [1:0]        op_fill,
    input  logic              op_swap,
    input  logic [WORD_W-1:0] src_word,
    input  logic [WORD_W-1:0] acc_word,
    output logic [WORD_W-1:0] res_word
);

    localparam int HALF_W = WORD_W / 2;

    htu_op_t           op;
    logic [HALF_W-1:0] src_hi, src_lo, acc_hi, acc_lo;
    logic [HALF_W-1:0] moved, other;
    logic              dst_right;
    logic [WORD_W-1:0] next_word;

    always_comb begin
        op.swap  = op_swap;
        op.route = route_e'(op_route);
        op.fill  = fill_e'(op_fill);
        src_hi   = src_word[WORD_W-1:HALF_W];
        src_lo   = src_word[HALF_W-1:0];
        acc_hi   = acc_word[WORD_W-1:HALF_W];
        acc_lo   = acc_word[HALF_W-1:0];
    end

    htu_route #(.HALF_W(HALF_W)) i_route (
        .route     (op.route),
        .src_hi    (src_hi),
        .src_lo    (src_lo),
        .moved     (moved),
        .dst_right (dst_right)
    );

    htu_fill #(.HALF_W(HALF_W)) i_fill (
        .fill      (op.fill),
        .dst_right (dst_right),
        .moved     (moved),
        .acc_hi    (acc_hi),
        .acc_lo    (acc_lo),
        .other     (other)
    );

    htu_pack #(.HALF_W(HALF_W)) i_pack (
        .swap      (op.swap),
        .dst_right (dst_right),
        .moved     (moved),
        .other     (other),
        .src_hi    (src_hi),
        .src_lo    (src_lo),
        .word      (next_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_word <= '0;
        end else if (op_valid) begin
            res_word <= next_word;
        end
    end

endmodule

// File: rtl/halfword_xfer_unit_chk.sv
module halfword_xfer_unit_chk #(
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [1:0]        op_route,
    input logic [1:0]        op_fill,
    input logic              op_swap,
    input logic [WORD_W-1:0] src_word,
    input logic [WORD_W-1:0] acc_word,
    input logic [WORD_W-1:0] res_word
);

    localparam int HALF_W = WORD_W / 2;

    logic              upd;
    logic [1:0]        c_route, c_fill;
    logic              c_swap;
    logic [WORD_W-1:0] c_src, c_acc;

    always_ff @(posedge clk) begin
        upd <= op_valid && !rst;
        if (op_valid) begin
            c_route <= op_route;
            c_fill  <= op_fill;
            c_swap  <= op_swap;
            c_src   <= src_word;
            c_acc   <= acc_word;
        end
    end

    logic              c_dst_r, c_src_r, c_sign;
    logic [HALF_W-1:0] r_dst, r_oth, s_pick, a_oth;

    always_comb begin
        c_dst_r = c_route[0];
        c_src_r = c_route[0] ^ c_route[1];
        s_pick  = c_src_r ? c_src[HALF_W-1:0] : c_src[WORD_W-1:HALF_W];
        c_sign  = c_src_r ? c_src[HALF_W-1] : c_src[WORD_W-1];
        r_dst   = c_dst_r ? res_word[HALF_W-1:0] : res_word[WORD_W-1:HALF_W];
        r_oth   = c_dst_r ? res_word[WORD_W-1:HALF_W] : res_word[HALF_W-1:0];
        a_oth   = c_dst_r ? c_acc[WORD_W-1:HALF_W] : c_acc[HALF_W-1:0];
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (res_word == '0)); // R1

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable(res_word)); // R2

    AST_MOVED_HALF: assert property (@(posedge clk) disable iff (rst)
        (upd && !c_swap) |-> (r_dst == s_pick)); // R3

    AST_KEEP_ACC: assert property (@(posedge clk) disable iff (rst)
        (upd && !c_swap && c_fill == 2'd0) |-> (r_oth == a_oth)); // R4

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (rst)
        (upd && !c_swap && c_fill == 2'd1) |-> (r_oth == '0)); // R5

    AST_ONES_FILL: assert property (@(posedge clk) disable iff (rst)
        (upd && !c_swap && c_fill == 2'd2) |-> (r_oth == '1)); // R6

    AST_SIGN_FILL: assert property (@(posedge clk) disable iff (rst)
        (upd && !c_swap && c_fill == 2'd3) |-> (r_oth == {HALF_W{c_sign}})); // R7

    AST_SWAP_HALVES: assert property (@(posedge clk) disable iff (rst)
        (upd && c_swap) |-> (res_word == {c_src[HALF_W-1:0], c_src[WORD_W-1:HALF_W]})); // R8

endmodule

bind halfword_xfer_unit halfword_xfer_unit_chk #(.WORD_W(WORD_W)) i_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_route (op_route),
    .op_fill  (op_fill),
    .op_swap  (op_swap),
    .src_word (src_word),
    .acc_word (acc_word),
    .res_word (res_word)
);

// File: tb/test_halfword_xfer_unit.sv
`timescale 1ns/1ps
module test_halfword_xfer_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [1:0]  op_route;
    logic [1:0]  op_fill;
    logic        op_swap;
    logic [35:0] src_word;
    logic [35:0] acc_word;
    logic [35:0] res_word;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    halfword_xfer_unit i_halfword_xfer_unit (
        .clk      (clk),
        .rst      (rst),
        .op_valid (op_valid),
        .op_route (op_route),
        .op_fill  (op_fill),
        .op_swap  (op_swap),
        .src_word (src_word),
        .acc_word (acc_word),
        .res_word (res_word)
    );

    function automatic logic [35:0] expect_word(input logic [1:0] r, input logic [1:0] f,
                                                input logic s, input logic [35:0] src,
                                                input logic [35:0] acc);
        logic [17:0] sl, sr, mv, oth;
        logic        to_left, sgn;
        sl = src[35:18];
        sr = src[17:0];
        if (s) return {sr, sl};
        case (r)
            2'd0: begin mv = sl; to_left = 1'b1; sgn = src[35]; end
            2'd1: begin mv = sr; to_left = 1'b0; sgn = src[17]; end
            2'd2: begin mv = sr; to_left = 1'b1; sgn = src[17]; end
            default: begin mv = sl; to_left = 1'b0; sgn = src[35]; end
        endcase
        case (f)
            2'd0: oth = to_left ? acc[17:0] : acc[35:18];
            2'd1: oth = 18'h00000;
            2'd2: oth = 18'h3FFFF;
            default: oth = sgn ? 18'h3FFFF : 18'h00000;
        endcase
        return to_left ? {mv, oth} : {oth, mv};
    endfunction

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(input string req, input logic [1:0] r, input logic [1:0] f,
                         input logic s, input logic [35:0] src, input logic [35:0] acc);
        @(negedge clk);
        op_valid = 1'b1;
        op_route = r;
        op_fill  = f;
        op_swap  = s;
        src_word = src;
        acc_word = acc;
        @(negedge clk);
        op_valid = 1'b0;
        check(req, res_word, expect_word(r, f, s, src, acc));
    endtask

    task automatic t_reset;
        rst      = 1'b1;
        op_valid = 1'b1;
        op_route = 2'd2;
        op_fill  = 2'd2;
        op_swap  = 1'b0;
        src_word = 36'hFFFFFFFFF;
        acc_word = 36'h123456789;
        repeat (3) @(negedge clk);
        check("R1 reset clears", res_word, 36'h0);
        op_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", res_word, 36'h0);
    endtask

    task automatic t_route_keep;
        for (int r = 0; r < 4; r++) begin
            do_op("R3 R4 route keep", 2'(r), 2'd0, 1'b0, 36'hA5C3_1_5A3C, 36'h3_C0FF_EE12);
        end
    endtask

    task automatic t_zero_ones;
        for (int r = 0; r < 4; r++) begin
            do_op("R5 zero fill", 2'(r), 2'd1, 1'b0, 36'h1234_5_6789, 36'hFFFFFFFFF);
            do_op("R6 ones fill", 2'(r), 2'd2, 1'b0, 36'h1234_5_6789, 36'h000000000);
        end
    endtask

    task automatic t_extend;
        for (int r = 0; r < 4; r++) begin
            // left half negative, right half positive
            do_op("R7 extend", 2'(r), 2'd3, 1'b0, {18'h2_0F0F, 18'h1_F0F0}, 36'h5A5A5A5A5);
            // left half positive, right half negative
            do_op("R7 extend", 2'(r), 2'd3, 1'b0, {18'h1_0F0F, 18'h2_F0F0}, 36'hA5A5A5A5A);
        end
    endtask

    task automatic t_swap;
        for (int k = 0; k < 4; k++) begin
            do_op("R8 swap", 2'(k), 2'(3 - k), 1'b1, {18'h3_1234, 18'h0_ABCD}, {9{4'(k)}});
        end
    endtask

    task automatic t_hold;
        logic [35:0] held;
        do_op("R2 load", 2'd2, 2'd1, 1'b0, 36'h0_0001_3FFF, 36'h0);
        held = res_word;
        @(negedge clk);
        op_route = 2'd3;
        op_fill  = 2'd2;
        op_swap  = 1'b1;
        src_word = 36'h987654321;
        acc_word = 36'hFFFFFFFFF;
        repeat (3) @(negedge clk);
        check("R2 hold without strobe", res_word, held);
        // latency: inputs applied but no edge yet
        op_valid = 1'b1;
        #2;
        check("R2 no change before edge", res_word, held);
        @(negedge clk);
        op_valid = 1'b0;
        check("R2 one edge latency", res_word, expect_word(2'd3, 2'd2, 1'b1, 36'h987654321, 36'hFFFFFFFFF));
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_route_keep();
        t_zero_ones();
        t_extend();
        t_swap();
        t_hold();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule